// File: doc/BRIEF.md
# Interleaved Memory Bank Conflict Controller

This block sits between a set of memory requesters and a sixteen-way interleaved word memory. Each requester offers a word address on a valid/ready port. The block picks one requester per clock by fixed priority. It splits the chosen address into a bank number (the low address bits) and a row within that bank (the remaining upper bits). The request is issued only if the target bank has finished its previous access cycle. A bank that has just been accessed stays occupied for a fixed number of clocks. A request aimed at an occupied bank is held, and the controller raises a stall indication for that cycle.

Requesters come in two classes. Fast requesters, such as vector and buffer ports, may be accepted on every clock. Slow requesters, such as the address and scalar register ports, are limited to one acceptance every two clocks. While a slow requester waits out its gap, a lower-priority requester may take the slot. Because consecutive word addresses land in consecutive banks, a constant-stride stream revisits a bank only after several other banks. Strides that are multiples of eight come back too soon and stall. Every other stride streams at one word per clock.

Top module: `membank_arbiter`

## Requirements
- R1: On an accepted request, `grant_bank` equals address bits [3:0] and `grant_row` equals address bits [19:4] of the accepted requester's address.
- R2: Among valid requesters that are not rate-blocked, the one with the lowest index is selected, and only it may see `req_ready` high.
- R3: After a bank accepts an access in cycle t, no access to that bank is accepted in cycles t+1 to t+3; it is accepted again from cycle t+4.
- R4: A fast requester (indices 0 and 1) can be accepted in every consecutive cycle while its targets are free banks.
- R5: A slow requester (indices 2 and 3) accepted in cycle t is not accepted in cycle t+1. During that blocked cycle, a lower-priority valid requester may be accepted instead.
- R6: `req_ready` has at most one bit set, and only for a valid requester. `grant_valid` is high exactly when a bit is set, and `grant_req` gives its index.
- R7: When the selected request targets a busy bank, `stall` is 1, no `req_ready` bit is set, and no bank timer is loaded that cycle.
- R8: After reset every bank and every rate gap is clear, so the first request after reset is accepted at once. With no valid request, `grant_valid`, `stall` and `req_ready` are 0.
- R9: A single fast requester streaming with a constant stride of 8 or 16 words sees stalls, while strides of 1, 3, 4, 5, 7 and 12 see none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_addr | input | NUM_REQ*ADDR_W | Packed word addresses; requester i at bits [i*ADDR_W +: ADDR_W] |
| req_ready | output | NUM_REQ | Per-requester acceptance, one-hot or zero |
| grant_valid | output | 1 | A request is issued to a bank this cycle |
| grant_req | output | $clog2(NUM_REQ) | Index of the accepted requester |
| grant_bank | output | BANK_BITS | Bank number of the issued access |
| grant_row | output | ADDR_W-BANK_BITS | Word row inside the bank |
| stall | output | 1 | Selected request is held on a busy bank |

## Verification
The bench builds the block with its defaults: four requesters, 20-bit addresses, sixteen banks, a four-cycle bank occupancy, a two-cycle gap for requesters 2 and 3. These values make the stride rule reachable. Strides of 8 and 16 return to a bank within four accesses, so the stall path and the unaffected-timer case appear in directed runs. Random traffic confined to a few banks with all four requesters active makes priority, rate blocking and conflicts coincide in the same cycles.

// File: rtl/membank_pkg.sv
package membank_pkg;
   localparam int unsigned MB_REQS      = 4;
   localparam int unsigned MB_ADDR_W    = 20;
   localparam int unsigned MB_BANK_BITS = 4;
   localparam int unsigned MB_BUSY      = 4;
   localparam int unsigned MB_SLOW_GAP  = 2;

   // Width of a down-counter that must hold values up to lim-1
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim > 2) ? $clog2(lim) : 1;
   endfunction
endpackage

// File: rtl/bank_timer.sv
module bank_timer
   import membank_pkg::*;
#(
   parameter int unsigned BUSY = MB_BUSY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic busy
);
   localparam int unsigned CW = cnt_width(BUSY);

   generate
      if (BUSY <= 1) begin : g_no_timer
         assign busy = 1'b0;
      end else begin : g_timer
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (hit)        cnt <= CW'(BUSY - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);

         AST_BUSY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> busy);                                   // R3
         AST_NO_HIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            busy |-> !hit);                                  // R3
      end
   endgenerate
endmodule

// File: rtl/rate_gate.sv
module rate_gate
   import membank_pkg::*;
#(
   parameter int unsigned GAP  = MB_SLOW_GAP,
   parameter bit          SLOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic ok
);
   localparam int unsigned CW = cnt_width(GAP);

   generate
      if (!SLOW || GAP <= 1) begin : g_full_rate
         assign ok = 1'b1;
      end else begin : g_limited
         logic [CW-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              gap_cnt <= '0;
            else if (fire)           gap_cnt <= CW'(GAP - 1);
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
         end
         assign ok = (gap_cnt == '0);

         AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> !ok);                                   // R5
         AST_FIRE_ONLY_WHEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
            fire |-> ok);                                    // R5
      end
   endgenerate
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]         cand,
   output logic                 found,
   output logic [$clog2(N)-1:0] idx,
   output logic [N-1:0]         onehot
);
   localparam int unsigned IW = $clog2(N);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

   assign onehot = cand & ~(cand - 1'b1);
endmodule

// File: rtl/membank_arbiter.sv
module membank_arbiter
   import membank_pkg::*;
#(
   parameter int unsigned          NUM_REQ     = MB_REQS,
   parameter int unsigned          ADDR_W      = MB_ADDR_W,
   parameter int unsigned          BANK_BITS   = MB_BANK_BITS,
   parameter int unsigned          BUSY_CYCLES = MB_BUSY,
   parameter int unsigned          SLOW_GAP    = MB_SLOW_GAP,
   parameter logic [NUM_REQ-1:0]   SLOW_MASK   = NUM_REQ'(4'b1100)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_REQ-1:0]            req_valid,
   input  logic [NUM_REQ*ADDR_W-1:0]     req_addr,
   output logic [NUM_REQ-1:0]            req_ready,
   output logic                          grant_valid,
   output logic [$clog2(NUM_REQ)-1:0]    grant_req,
   output logic [BANK_BITS-1:0]          grant_bank,
   output logic [ADDR_W-BANK_BITS-1:0]   grant_row,
   output logic                          stall
);
   localparam int unsigned NUM_BANKS = 1 << BANK_BITS;
   localparam int unsigned ROW_W     = ADDR_W - BANK_BITS;
   localparam int unsigned IW        = $clog2(NUM_REQ);

   generate
      if (NUM_REQ < 2)                $error("NUM_REQ must be at least 2");
      if (BANK_BITS < 1)              $error("BANK_BITS must be at least 1");
      if (ADDR_W <= BANK_BITS)        $error("ADDR_W must exceed BANK_BITS");
      if (BUSY_CYCLES < 1)            $error("BUSY_CYCLES must be at least 1");
      if (SLOW_GAP < 1)               $error("SLOW_GAP must be at least 1");
   endgenerate

   logic [NUM_REQ-1:0]   rate_ok;
   logic [NUM_REQ-1:0]   cand;
   logic [NUM_REQ-1:0]   pick_oh;
   logic                 found;
   logic [IW-1:0]        pick_idx;
   logic [ADDR_W-1:0]    sel_addr;
   logic [BANK_BITS-1:0] sel_bank;
   logic [NUM_BANKS-1:0] bank_busy;
   logic [NUM_BANKS-1:0] bank_hit;
   logic                 issue;

   // Per-requester issue-rate gates: variant chosen by SLOW_MASK
   for (genvar r = 0; r < NUM_REQ; r++) begin : g_rate
      rate_gate #(
         .GAP  (SLOW_GAP),
         .SLOW (SLOW_MASK[r])
      ) u_gate (
         .clk   (clk),
         .rst_n (rst_n),
         .fire  (req_ready[r]),
         .ok    (rate_ok[r])
      );
   end

   assign cand = req_valid & rate_ok;

   prio_pick #(.N(NUM_REQ)) u_pick (
      .cand   (cand),
      .found  (found),
      .idx    (pick_idx),
      .onehot (pick_oh)
   );

   assign sel_addr = req_addr[int'(pick_idx) * ADDR_W +: ADDR_W];
   assign sel_bank = sel_addr[BANK_BITS-1:0];

   assign stall = found & bank_busy[sel_bank];
   assign issue = found & ~bank_busy[sel_bank];

   // Per-bank occupancy timers
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_hit[b] = issue && (sel_bank == BANK_BITS'(b));
      bank_timer #(.BUSY(BUSY_CYCLES)) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (bank_hit[b]),
         .busy  (bank_busy[b])
      );
   end

   assign req_ready   = issue ? pick_oh : '0;
   assign grant_valid = issue;
   assign grant_req   = pick_idx;
   assign grant_bank  = sel_bank;
   assign grant_row   = sel_addr[ADDR_W-1 -: ROW_W];

   AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));                                       // R6
   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);                            // R6
   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (req_ready == '0 && bank_hit == '0));             // R7
   AST_SINGLE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_hit) == (grant_valid ? 1 : 0));             // R3
endmodule

// File: tb/membank_arbiter_bench.sv
module membank_arbiter_bench;
   localparam int NR = 4;
   localparam int AW = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NR-1:0]   v = '0;
   logic [AW-1:0]   a [NR];
   logic [NR*AW-1:0] req_addr;
   logic [NR-1:0]   req_ready;
   logic            grant_valid;
   logic [1:0]      grant_req;
   logic [3:0]      grant_bank;
   logic [15:0]     grant_row;
   logic            stall;

   int vectors = 0;
   int miscompares = 0;
   int m_bank [16];
   int m_gap  [NR];
   logic [NR-1:0] last_ready;
   int n_grant, n_stall;
   localparam logic [NR-1:0] SLOW = 4'b1100;

   always #2 clk = ~clk;

   always_comb
      for (int i = 0; i < NR; i++) req_addr[i*AW +: AW] = a[i];

   membank_arbiter u_membank_arbiter (
      .clk(clk), .rst_n(rst_n), .req_valid(v), .req_addr(req_addr),
      .req_ready(req_ready), .grant_valid(grant_valid), .grant_req(grant_req),
      .grant_bank(grant_bank), .grant_row(grant_row), .stall(stall)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pick_expected();
      for (int i = 0; i < NR; i++)
         if (v[i] && (!SLOW[i] || m_gap[i] == 0)) return i;
      return -1;
   endfunction

   // One clock: inputs were driven at the falling edge; compare just after,
   // then advance the model as the rising edge will.
   task automatic cycle();
      int ei, eb;
      bit es, eg;
      logic [NR-1:0] er;
      #1;
      ei = pick_expected();
      eb = (ei >= 0) ? int'(a[ei][3:0]) : 0;
      es = (ei >= 0) && (m_bank[eb] != 0);
      eg = (ei >= 0) && !es;
      er = eg ? NR'(1 << ei) : '0;
      chk(grant_valid === eg, "R3 grant_valid", grant_valid, eg);
      chk(req_ready === er, "R2 req_ready", req_ready, er);
      chk(stall === es, "R7 stall", stall, es);
      if (eg) begin
         chk(grant_bank === a[ei][3:0], "R1 bank", grant_bank, a[ei][3:0]);
         chk(grant_row === a[ei][19:4], "R1 row", grant_row, a[ei][19:4]);
         chk(grant_req === ei[1:0], "R6 grant_req", grant_req, ei);
      end
      if (grant_valid === 1'b1) n_grant++;
      if (stall === 1'b1) n_stall++;
      for (int b = 0; b < 16; b++) if (m_bank[b] != 0) m_bank[b]--;
      for (int i = 0; i < NR; i++) if (m_gap[i] != 0) m_gap[i]--;
      if (eg) begin
         m_bank[eb] = 3;
         if (SLOW[ei]) m_gap[ei] = 1;
      end
      last_ready = er;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      v = '0;
      for (int k = 0; k < n; k++) cycle();
   endtask

   // Single fast requester, constant stride, 32 accepted words
   task automatic run_stride(input int s, input bit want_stall);
      int done;
      idle(4);
      n_stall = 0;
      done = 0;
      a[0] = 20'h00123;
      v = 4'b0001;
      while (done < 32) begin
         cycle();
         if (last_ready[0]) begin
            done++;
            a[0] = a[0] + AW'(s);
         end
      end
      v = '0;
      if (want_stall)
         chk(n_stall > 0, $sformatf("R9 stride %0d stalls", s), n_stall, 1);
      else
         chk(n_stall == 0, $sformatf("R9 stride %0d stalls", s), n_stall, 0);
   endtask

   initial begin
      #(200000 * 4);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < NR; i++) a[i] = '0;
      for (int b = 0; b < 16; b++) m_bank[b] = 0;
      for (int i = 0; i < NR; i++) m_gap[i] = 0;
      repeat (3) @(negedge clk);
      #1;
      // R8: idle outputs during reset
      chk(grant_valid === 1'b0, "R8 reset grant_valid", grant_valid, 0);
      chk(stall === 1'b0, "R8 reset stall", stall, 0);
      chk(req_ready === '0, "R8 reset req_ready", req_ready, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 + R2: all four on bank 5, first cycle after reset goes to index 0
      for (int i = 0; i < NR; i++) a[i] = {16'(i + 7), 4'd5};
      v = 4'b1111;
      cycle();
      chk(last_ready == 4'b0001, "R8 first request accepted", last_ready, 1);
      v[0] = 1'b0;
      // R3/R7: index 1 waits three stalled cycles for bank 5
      n_stall = 0;
      cycle(); cycle(); cycle();
      chk(n_stall == 3, "R7 stalls on busy bank", n_stall, 3);
      cycle();
      chk(last_ready == 4'b0010, "R3 bank free after 4 cycles", last_ready, 2);
      idle(4);

      // R4: fast requester every cycle over consecutive banks
      n_grant = 0;
      v = 4'b0001;
      for (int k = 0; k < 16; k++) begin a[0] = AW'(k); cycle(); end
      chk(n_grant == 16, "R4 full rate", n_grant, 16);

      // R5: slow requester alone gets every other cycle
      idle(2);
      n_grant = 0;
      v = 4'b0100;
      for (int k = 0; k < 10; k++) begin
         cycle();
         if (last_ready[2]) a[2] = a[2] + 1'b1;
      end
      chk(n_grant == 5, "R5 slow rate", n_grant, 5);

      // R5: blocked slow requester yields to lower priority one
      idle(4);
      a[2] = 20'h00011; a[3] = 20'h00022;
      v = 4'b1100;
      cycle();
      chk(last_ready == 4'b0100, "R5 slow first", last_ready, 4);
      a[2] = 20'h00033;
      cycle();
      chk(last_ready == 4'b1000, "R5 lower priority fills gap", last_ready, 8);
      idle(4);

      // R9: stride behaviour
      run_stride(1, 0);  run_stride(3, 0);  run_stride(4, 0);
      run_stride(5, 0);  run_stride(7, 0);  run_stride(12, 0);
      run_stride(8, 1);  run_stride(16, 1);

      // Random traffic on a few banks; pending requests hold their address
      idle(4);
      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < NR; i++) begin
            if (!v[i] || last_ready[i]) begin
               v[i] = ($urandom_range(0, 3) != 0);
               a[i] = {16'($urandom), 4'($urandom_range(0, 5))};
            end
         end
         cycle();
      end
      idle(2);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule